// File: doc/BRIEF.md
# Raster Line Timing and Status Interrupt Generator

This block paces a raster display. A cycle counter splits every scanline into an active (drawing) part and a horizontal-blank part, and a line counter steps through the visible lines and then the vertical-blank lines of each frame. From these two counters the block keeps three status flags: in horizontal blank, in vertical blank, and current line equals the programmed compare line. It also emits one-cycle interrupt request pulses toward an interrupt controller.

A host writes one status word that holds three interrupt enables and a line-compare value. In the same word the three flags read back, and writes cannot change them. The block also exports the current line number and a draw strobe. The draw strobe marks the end of each visible line's active part, so a renderer downstream knows when to produce that line.

By default each line has 960 active cycles and 272 blank cycles. There are 160 visible lines in a frame of 228 lines. All of these counts are parameters.

Top module: `disp_timing`

## Requirements
- R1: After reset the line count is 0 and the cycle position is 0 in the active part. All three flags, all enables and the compare field read 0, and no request or draw pulse is high.
- R2: Each line has ACTIVE_CYC active cycles followed by HBLANK_CYC blank cycles. The hblank flag (status bit 1) rises on the first blank cycle and falls in the cycle in which the line count advances.
- R3: The line count advances once per line, at the end of the blank part, and wraps from TOTAL_LINES-1 to 0.
- R4: The draw strobe is a one-cycle pulse on the first blank cycle of lines 0 to VIS_LINES-1 only.
- R5: The vblank flag (status bit 0) sets when the line count becomes VIS_LINES and clears when it becomes TOTAL_LINES-1. The last line of the frame therefore reads as not in vertical blank.
- R6: The match flag (status bit 2) is written only when the line count advances. It takes the value "new line equals compare field", and it reads 0 until the first advance after reset.
- R7: When the match flag is set by an advance and the match enable (status bit 5) is 1, the match request pulses for one cycle in the same cycle.
- R8: When the hblank enable (status bit 4) is 1, the hblank request pulses for one cycle on the first blank cycle of every line, both visible and vertical-blank lines.
- R9: When the vblank enable (status bit 3) is 1, the vblank request pulses for one cycle, once per frame, in the cycle the line count becomes VIS_LINES.
- R10: A status write loads the enables from bits 5:3 and the compare field from bits STAT_W-1:8. It ignores bits 2:0, so the flags keep their values. Bits 7:6 read 0.
- R11: A request whose enable is 0 never pulses. An enable change takes effect from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_wr_en | input | 1 | Status word write strobe |
| stat_wr_data | input | STAT_W | Status word write value (enables and compare) |
| stat_rd_data | output | STAT_W | Status word: flags, enables, compare field |
| line_count | output | LINE_W | Current line number |
| irq_hblank | output | 1 | Horizontal-blank request pulse |
| irq_vblank | output | 1 | Vertical-blank request pulse |
| irq_match | output | 1 | Line-match request pulse |
| draw_line | output | 1 | End-of-active strobe on visible lines |

## Verification
The bench checks the frame edges: the wrap from the last line to line 0, the vblank flag clearing on the last line, and compare values of 0 and of the last line. A design that cleared vblank one line late, or that failed to match on the wrap, would show the wrong flag in exactly those cycles. It also checks that hblank requests and draw strobes separate in vertical-blank lines; a design that gated hblank requests on visible lines would lose those pulses. Writes are placed while the vblank flag is set and also while it is clear, with the flag bits in the write data opposite to the current flags. A design that let a write reach a flag would flip it at once. The match flag is also checked when it goes stale: a design that compared continuously, instead of only at each advance, would fail this.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;

    // Source index: flag bit, enable bit offset and request vector share it.
    localparam int SRC_VB  = 0;
    localparam int SRC_HB  = 1;
    localparam int SRC_MT  = 2;
    localparam int NUM_SRC = 3;

    // Status word layout.
    localparam int ST_FLAG_LSB = 0;
    localparam int ST_IE_LSB   = 3;
    localparam int ST_CMP_LSB  = 8;

endpackage

// File: rtl/disp_cycle_timer.sv
module disp_cycle_timer #(
    parameter int ACTIVE_CYC = 960,
    parameter int HBLANK_CYC = 272
) (
    input  logic clk,
    input  logic rst_n,
    output logic end_active,
    output logic end_line
);
    localparam int LINE_CYC = ACTIVE_CYC + HBLANK_CYC;
    localparam int CYC_W    = $clog2(LINE_CYC);
    localparam logic [CYC_W-1:0] LAST_ACT  = CYC_W'(ACTIVE_CYC - 1);
    localparam logic [CYC_W-1:0] LAST_LINE = CYC_W'(LINE_CYC - 1);

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cyc == LAST_LINE) s_d.cyc = '0;
        else                      s_d.cyc = s_q.cyc + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign end_active = (s_q.cyc == LAST_ACT);
    assign end_line   = (s_q.cyc == LAST_LINE);

    AST_CYC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cyc <= LAST_LINE) else $error("cycle counter out of range"); // R2

endmodule

// File: rtl/disp_line_counter.sv
module disp_line_counter #(
    parameter int TOTAL_LINES = 228,
    parameter int LINE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [LINE_W-1:0] line_q_o,
    output logic [LINE_W-1:0] line_next_o
);
    localparam logic [LINE_W-1:0] LAST = LINE_W'(TOTAL_LINES - 1);

    typedef struct packed {
        logic [LINE_W-1:0] line;
    } lc_t;

    lc_t s_d, s_q;
    logic [LINE_W-1:0] wrapped_d;

    always_comb begin
        wrapped_d = (s_q.line == LAST) ? '0 : s_q.line + 1'b1;
        s_d = s_q;
        if (advance) s_d.line = wrapped_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign line_q_o    = s_q.line;
    assign line_next_o = wrapped_d;

    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && s_q.line == LAST) |=> (s_q.line == '0)) else $error("line wrap wrong"); // R3

endmodule

// File: rtl/disp_status.sv
module disp_status
    import disp_timing_pkg::*;
#(
    parameter int VIS_LINES   = 160,
    parameter int TOTAL_LINES = 228,
    parameter int LINE_W      = 8,
    parameter int STAT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              end_active,
    input  logic              end_line,
    input  logic [LINE_W-1:0] cur_line,
    input  logic [LINE_W-1:0] next_line,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] rd_data,
    output logic [NUM_SRC-1:0] irq_o,
    output logic              draw_o
);
    localparam logic [LINE_W-1:0] VB_FIRST = LINE_W'(VIS_LINES);
    localparam logic [LINE_W-1:0] VB_OFF   = LINE_W'(TOTAL_LINES - 1);

    typedef struct packed {
        logic [NUM_SRC-1:0] flag;
        logic [NUM_SRC-1:0] ie;
        logic [LINE_W-1:0]  cmp;
        logic [NUM_SRC-1:0] irq;
        logic               draw;
    } st_t;

    st_t  s_d, s_q;
    logic hit_d;

    always_comb begin
        s_d      = s_q;
        s_d.irq  = '0;
        s_d.draw = 1'b0;
        hit_d    = (next_line == s_q.cmp);

        if (wr_en) begin
            s_d.ie  = wr_data[ST_IE_LSB +: NUM_SRC];
            s_d.cmp = wr_data[ST_CMP_LSB +: LINE_W];
        end

        if (end_active) begin
            s_d.flag[SRC_HB] = 1'b1;
            s_d.irq[SRC_HB]  = s_q.ie[SRC_HB];
            s_d.draw         = (cur_line < VB_FIRST);
        end

        if (end_line) begin
            s_d.flag[SRC_HB] = 1'b0;
            s_d.flag[SRC_MT] = hit_d;
            s_d.irq[SRC_MT]  = hit_d & s_q.ie[SRC_MT];
            if (next_line == VB_FIRST) begin
                s_d.flag[SRC_VB] = 1'b1;
                s_d.irq[SRC_VB]  = s_q.ie[SRC_VB];
            end
            if (next_line == VB_OFF) s_d.flag[SRC_VB] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data = '0;
        rd_data[ST_FLAG_LSB +: NUM_SRC] = s_q.flag;
        rd_data[ST_IE_LSB +: NUM_SRC]   = s_q.ie;
        rd_data[ST_CMP_LSB +: LINE_W]   = s_q.cmp;
    end

    assign irq_o  = s_q.irq;
    assign draw_o = s_q.draw;

    AST_DRAW_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.draw |-> (s_q.flag[SRC_HB] && cur_line < VB_FIRST)) else $error("draw outside visible"); // R4
    AST_VB_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq[SRC_VB] |-> (s_q.flag[SRC_VB] && cur_line == VB_FIRST)) else $error("vblank req misplaced"); // R9
    AST_MATCH_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq[SRC_MT] |-> (s_q.flag[SRC_MT] && cur_line == s_q.cmp)) else $error("match req without match"); // R7
    AST_HB_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq[SRC_HB] |-> $past(s_q.ie[SRC_HB])) else $error("hblank req while disabled"); // R11
    AST_VB_LAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_line == VB_OFF) |-> !s_q.flag[SRC_VB]) else $error("vblank set on last line"); // R5

endmodule

// File: rtl/disp_timing.sv
module disp_timing
    import disp_timing_pkg::*;
#(
    parameter int ACTIVE_CYC  = 960,
    parameter int HBLANK_CYC  = 272,
    parameter int VIS_LINES   = 160,
    parameter int TOTAL_LINES = 228,
    localparam int LINE_W     = $clog2(TOTAL_LINES),
    localparam int STAT_W     = ST_CMP_LSB + LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr_en,
    input  logic [STAT_W-1:0] stat_wr_data,
    output logic [STAT_W-1:0] stat_rd_data,
    output logic [LINE_W-1:0] line_count,
    output logic              irq_hblank,
    output logic              irq_vblank,
    output logic              irq_match,
    output logic              draw_line
);
    logic               end_active, end_line;
    logic [LINE_W-1:0]  next_line;
    logic [NUM_SRC-1:0] irq_vec;

    disp_cycle_timer #(
        .ACTIVE_CYC(ACTIVE_CYC),
        .HBLANK_CYC(HBLANK_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .end_active(end_active),
        .end_line  (end_line)
    );

    disp_line_counter #(
        .TOTAL_LINES(TOTAL_LINES),
        .LINE_W     (LINE_W)
    ) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (end_line),
        .line_q_o   (line_count),
        .line_next_o(next_line)
    );

    disp_status #(
        .VIS_LINES  (VIS_LINES),
        .TOTAL_LINES(TOTAL_LINES),
        .LINE_W     (LINE_W),
        .STAT_W     (STAT_W)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .end_active(end_active),
        .end_line  (end_line),
        .cur_line  (line_count),
        .next_line (next_line),
        .wr_en     (stat_wr_en),
        .wr_data   (stat_wr_data),
        .rd_data   (stat_rd_data),
        .irq_o     (irq_vec),
        .draw_o    (draw_line)
    );

    assign irq_vblank = irq_vec[SRC_VB];
    assign irq_hblank = irq_vec[SRC_HB];
    assign irq_match  = irq_vec[SRC_MT];

    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        line_count < LINE_W'(TOTAL_LINES)) else $error("line count out of range"); // R3
    AST_HB_CLEAR_ON_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (line_count != $past(line_count)) |-> !stat_rd_data[ST_FLAG_LSB + SRC_HB]) else $error("hblank kept across advance"); // R2

endmodule

// File: tb/disp_timing_test.sv
`timescale 1ns/1ps
module disp_timing_test;
    localparam int ACT = 8;
    localparam int HBL = 4;
    localparam int VIS = 4;
    localparam int TOT = 7;
    localparam int LCY = ACT + HBL;
    localparam int LW  = $clog2(TOT);
    localparam int SW  = 8 + LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [SW-1:0] wr_data = '0;
    logic [SW-1:0] rd_data;
    logic [LW-1:0] line_count;
    logic          irq_hb, irq_vb, irq_mt, draw;

    int checks = 0;
    int fails  = 0;
    int k      = 0;
    logic       m_match = 1'b0;
    logic [2:0] m_ie    = 3'b000;
    logic [LW-1:0] m_cmp = '0;

    always #10 clk = ~clk;

    always @(posedge clk or negedge rst_n)
        if (!rst_n) k <= 0;
        else        k <= k + 1;

    disp_timing #(
        .ACTIVE_CYC(ACT), .HBLANK_CYC(HBL), .VIS_LINES(VIS), .TOTAL_LINES(TOT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .stat_wr_en(wr_en), .stat_wr_data(wr_data),
        .stat_rd_data(rd_data), .line_count(line_count),
        .irq_hblank(irq_hb), .irq_vblank(irq_vb), .irq_match(irq_mt), .draw_line(draw)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at k=%0d: actual %0d expected %0d", tag, k, act, exp);
        end
    endtask

    // Reference from requirements: position derived from edges since reset.
    task automatic check_now();
        int cyc, ln;
        logic hb, vb;
        logic [SW-1:0] exp_rd;
        cyc = k % LCY;
        ln  = (k / LCY) % TOT;
        if (cyc == 0 && k > 0) m_match = (ln == int'(m_cmp));
        hb = (cyc >= ACT);
        vb = (ln >= VIS) && (ln < TOT - 1);
        chk("R3 line_count", int'(line_count), ln);
        chk("R2 hblank flag", int'(rd_data[1]), int'(hb));
        chk("R5 vblank flag", int'(rd_data[0]), int'(vb));
        chk("R6 match flag", int'(rd_data[2]), int'(m_match));
        chk("R4 draw strobe", int'(draw), int'(cyc == ACT && ln < VIS));
        chk("R8 R11 hblank req", int'(irq_hb), int'(cyc == ACT && m_ie[1]));
        chk("R9 R11 vblank req", int'(irq_vb), int'(cyc == 0 && k > 0 && ln == VIS && m_ie[0]));
        chk("R7 R11 match req", int'(irq_mt), int'(cyc == 0 && k > 0 && ln == int'(m_cmp) && m_ie[2]));
        exp_rd = '0;
        exp_rd[0] = vb; exp_rd[1] = hb; exp_rd[2] = m_match;
        exp_rd[5:3] = m_ie;
        exp_rd[SW-1:8] = m_cmp;
        chk("R10 status word", int'(rd_data), int'(exp_rd));
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_now();
        end
    endtask

    // Write at cycle 2 of a line (line < 0 means any line); flag bits carry junk.
    task automatic do_write(input int line_sel, input logic [2:0] ie,
                            input logic [LW-1:0] cmp, input logic [2:0] junk);
        while (!((k % LCY) == 2 && (line_sel < 0 || (k / LCY) % TOT == line_sel)))
            step(1);
        wr_en   = 1'b1;
        wr_data = {cmp, 2'b11, ie, junk};
        m_ie    = ie;
        m_cmp   = cmp;
        step(1);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        m_match = 1'b0; m_ie = 3'b000; m_cmp = '0;
        chk("R1 line", int'(line_count), 0);
        chk("R1 status", int'(rd_data), 0);
        chk("R1 pulses", int'({irq_hb, irq_vb, irq_mt, draw}), 0);
        rst_n = 1'b1;
        step(2);
    endtask

    // R2 R3 R4 R5 R11: free run, all enables off, over a frame wrap
    task automatic t_idle_frame();
        step(LCY * TOT + 20);
    endtask

    // R6 R7 R8 R9: all enables on, compare on a visible line
    task automatic t_all_irqs();
        do_write(-1, 3'b111, LW'(2), 3'b000);
        step(LCY * TOT * 2);
    endtask

    // R6 R7: compare at the frame edges (line 0 via wrap, last line)
    task automatic t_edge_compare();
        do_write(-1, 3'b100, LW'(0), 3'b000);
        step(LCY * TOT + 5);
        do_write(-1, 3'b100, LW'(TOT - 1), 3'b000);
        step(LCY * TOT + 5);
    endtask

    // R10: flag bits in writes are ignored, both polarities
    task automatic t_readonly();
        do_write(VIS, 3'b010, LW'(3), 3'b000);
        step(LCY);
        do_write(0, 3'b001, LW'(5), 3'b111);
        step(LCY * 2);
    endtask

    // R11: everything disabled again
    task automatic t_disabled();
        do_write(-1, 3'b000, LW'(1), 3'b000);
        step(LCY * TOT + 3);
    endtask

    initial begin
        t_reset();
        t_idle_frame();
        t_all_irqs();
        t_edge_compare();
        t_readonly();
        t_disabled();
        t_reset();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule